// File: doc/BRIEF.md
# Counter Count/Status Latch Unit

This block sits between an 8-bit internal bus and one 16-bit counting element of a programmable interval timer channel. It collects count bytes written by software, in the byte order chosen by the channel's control word, and hands a complete count to the counting channel as one atomic transfer. It also returns count and status bytes for bus reads. A count snapshot and a status snapshot can each be frozen on request.

A command decoder outside the block drives one-cycle strobes: control word write, byte write, byte read, count latch and status latch. The counting channel reports its live value, its output pin level and a load strobe when it takes the count register. Reads are combinational. `rdata_o` always shows the byte that a read would return now, and `rd_i` consumes it at the clock edge. Writes and reads keep separate byte pointers, so bytes of the two directions can be interleaved freely.

Top module: `cnt_latch_unit`

## Requirements
- R1: After reset the stored control word is 0x30, that is two-byte format 11, mode 0 and binary. The null-count flag is 1, `cr_o` is 0 and `cr_valid_o` is 0. No latch is held, so `rdata_o` shows the live low byte.
- R2: Format bits cw[5:4] pick the write order. With 01 the written byte becomes the low byte and the high byte is 0. With 10 it becomes the high byte and the low byte is 0. With 11 the first byte is the low byte and the second is the high byte. On the cycle after the byte that completes a count, `cr_o` holds the new value and `cr_valid_o` is 1.
- R3: In format 11 the first byte changes neither `cr_o` nor `cr_valid_o`. `cr_valid_o` is high for exactly one cycle for each completed count.
- R4: A count latch freezes the value of `ce_value_i` taken at that edge. While the snapshot is held, a further count latch is ignored. The snapshot is released once the programmed number of bytes has been read, and reads then follow `ce_value_i` again.
- R5: A status latch captures the byte {out pin, null count, cw[5:0]}, with the out pin in bit 7, null count in bit 6 and the control word in bits 5..0. A second status latch issued before that byte is read is ignored.
- R6: If status and count are both latched, the next read returns status whichever was latched first. The following one or two reads return the frozen count, and later reads return live bytes.
- R7: Null count goes to 1 on a control word write and on the cycle after a count is completed. It goes to 0 on `ce_load_i`. When a set and a clear fall in the same cycle, the set wins.
- R8: The read and write byte pointers are independent. The sequence read low, write low, read high, write high returns both frozen bytes and loads the full new count.
- R9: A control word write resets both byte pointers and drops any held count or status latch. Latch requests in that same cycle are ignored.
- R10: A read with no latch held returns live bytes. Format 01 always returns the low byte and format 10 always returns the high byte. Format 11 alternates low, then high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cw_we_i | input | 1 | Control word write strobe for this channel |
| cw_i | input | 6 | Control word: format [5:4], mode [3:1], BCD [0] |
| wr_i | input | 1 | Count byte write strobe |
| wdata_i | input | 8 | Count byte to write |
| rd_i | input | 1 | Byte read strobe; consumes the byte shown on rdata_o |
| cnt_latch_i | input | 1 | Count latch request |
| sts_latch_i | input | 1 | Status latch request |
| ce_value_i | input | 16 | Live value of the counting element |
| ce_load_i | input | 1 | Counting element has taken cr_o |
| out_pin_i | input | 1 | Current channel output level |
| cw_o | output | 6 | Stored control word, passed to the counting channel |
| cr_o | output | 16 | Complete count register |
| cr_valid_o | output | 1 | One-cycle pulse when cr_o holds a new complete count |
| rdata_o | output | 8 | Byte a read returns now |

## Verification
A read pointer that has slipped shows up at once on `rdata_o` as a high byte where a low byte was expected, and it stays wrong for every later byte until a control word write resets it. A latch flag that fails to clear shows as a stale snapshot on the next read. One that fails to set shows as a live value leaking through on the first byte read after the latch. A wrong write pointer or staging error appears on `cr_o` one cycle after the completing byte. A wrong null-count flag is visible only through bit 6 of the next latched status byte.

// File: rtl/cl_pkg.sv
package cl_pkg;
  typedef enum logic [1:0] {
    RW_CMD  = 2'b00,
    RW_LO   = 2'b01,
    RW_HI   = 2'b10,
    RW_LOHI = 2'b11
  } rw_fmt_e;

  localparam int CwW = 6;
  localparam logic [CwW-1:0] CwReset = 6'h30;
endpackage

// File: rtl/cl_wr_path.sv
module cl_wr_path
  import cl_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CntW = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_we_i,
  input  rw_fmt_e           fmt_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              ce_load_i,
  output logic [CntW-1:0]   cr_o,
  output logic              cr_valid_o,
  output logic              null_cnt_o
);
  logic              wptr_q;
  logic [BYTE_W-1:0] lo_stage_q;
  logic              complete;

  // a count is complete on a single-byte write or on the second byte of a pair
  always_comb begin
    complete = 1'b0;
    if (wr_i && !cw_we_i) begin
      unique case (fmt_i)
        RW_LO, RW_HI: complete = 1'b1;
        RW_LOHI:      complete = wptr_q;
        default:      complete = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cr_o       <= '0;
      cr_valid_o <= 1'b0;
      wptr_q     <= 1'b0;
      lo_stage_q <= '0;
    end else begin
      cr_valid_o <= complete;
      if (cw_we_i) begin
        wptr_q <= 1'b0;
      end else if (wr_i) begin
        unique case (fmt_i)
          RW_LO: cr_o <= {{BYTE_W{1'b0}}, wdata_i};
          RW_HI: cr_o <= {wdata_i, {BYTE_W{1'b0}}};
          RW_LOHI: begin
            if (!wptr_q) begin
              lo_stage_q <= wdata_i;
              wptr_q     <= 1'b1;
            end else begin
              cr_o   <= {wdata_i, lo_stage_q};
              wptr_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  null_cnt_o <= 1'b1;
    else if (cw_we_i || complete) null_cnt_o <= 1'b1;
    else if (ce_load_i)           null_cnt_o <= 1'b0;
  end

  a_r3_no_pulse_on_first_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !cw_we_i && fmt_i == RW_LOHI && !wptr_q) |=> (!cr_valid_o && $stable(cr_o)));
  a_r7_new_count_flags_null: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cr_valid_o |-> null_cnt_o);
  a_r2_low_only_high_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cr_valid_o && fmt_i == RW_LO) |-> (cr_o[CntW-1:BYTE_W] == '0));
  a_r9_cw_resets_wptr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_we_i |=> !wptr_q);
endmodule

// File: rtl/cl_rd_path.sv
module cl_rd_path
  import cl_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CntW = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_we_i,
  input  rw_fmt_e           fmt_i,
  input  logic              rd_i,
  input  logic              cnt_latch_i,
  input  logic              sts_latch_i,
  input  logic [CntW-1:0]   ce_value_i,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [CntW-1:0]   ol_q;
  logic              ol_held_q;
  logic [BYTE_W-1:0] st_q;
  logic              st_held_q;
  logic              rptr_q;
  logic [CntW-1:0]   src;
  logic              hi_sel;
  logic              last_byte;

  assign src       = ol_held_q ? ol_q : ce_value_i;
  assign hi_sel    = (fmt_i == RW_HI) || (fmt_i == RW_LOHI && rptr_q);
  assign last_byte = (fmt_i != RW_LOHI) || rptr_q;
  assign rdata_o   = st_held_q ? st_q
                   : (hi_sel ? src[CntW-1:BYTE_W] : src[BYTE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ol_q      <= '0;
      ol_held_q <= 1'b0;
      st_q      <= '0;
      st_held_q <= 1'b0;
      rptr_q    <= 1'b0;
    end else if (cw_we_i) begin
      ol_held_q <= 1'b0;
      st_held_q <= 1'b0;
      rptr_q    <= 1'b0;
    end else begin
      if (rd_i) begin
        if (st_held_q) begin
          st_held_q <= 1'b0;
        end else if (last_byte) begin
          rptr_q    <= 1'b0;
          ol_held_q <= 1'b0;
        end else begin
          rptr_q <= 1'b1;
        end
      end
      // first request wins; a held snapshot ignores new requests
      if (cnt_latch_i && !ol_held_q) begin
        ol_q      <= ce_value_i;
        ol_held_q <= 1'b1;
      end
      if (sts_latch_i && !st_held_q) begin
        st_q      <= status_i;
        st_held_q <= 1'b1;
      end
    end
  end

  a_r4_second_count_latch_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ol_held_q && cnt_latch_i) |=> $stable(ol_q));
  a_r5_second_status_latch_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_held_q && sts_latch_i) |=> $stable(st_q));
  a_r6_status_read_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_held_q && ol_held_q && rd_i && !cw_we_i) |=> (ol_held_q && !st_held_q && $stable(rptr_q)));
  a_r9_cw_releases_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_we_i |=> (!ol_held_q && !st_held_q && !rptr_q));
endmodule

// File: rtl/cnt_latch_unit.sv
module cnt_latch_unit
  import cl_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CntW = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cw_we_i,
  input  logic [CwW-1:0]    cw_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              cnt_latch_i,
  input  logic              sts_latch_i,
  input  logic [CntW-1:0]   ce_value_i,
  input  logic              ce_load_i,
  input  logic              out_pin_i,
  output logic [CwW-1:0]    cw_o,
  output logic [CntW-1:0]   cr_o,
  output logic              cr_valid_o,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [CwW-1:0]    cw_q;
  rw_fmt_e           fmt;
  logic              null_cnt;
  logic [BYTE_W-1:0] status;
  logic [BYTE_W-3:0] cw_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cw_q <= CwReset;
    else if (cw_we_i) cw_q <= cw_i;
  end

  assign cw_o   = cw_q;
  assign fmt    = rw_fmt_e'(cw_q[CwW-1:CwW-2]);
  assign cw_ext = (BYTE_W-2)'(cw_q);
  assign status = {out_pin_i, null_cnt, cw_ext};

  cl_wr_path #(.BYTE_W(BYTE_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cw_we_i    (cw_we_i),
    .fmt_i      (fmt),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .ce_load_i  (ce_load_i),
    .cr_o       (cr_o),
    .cr_valid_o (cr_valid_o),
    .null_cnt_o (null_cnt)
  );

  cl_rd_path #(.BYTE_W(BYTE_W)) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cw_we_i     (cw_we_i),
    .fmt_i       (fmt),
    .rd_i        (rd_i),
    .cnt_latch_i (cnt_latch_i),
    .sts_latch_i (sts_latch_i),
    .ce_value_i  (ce_value_i),
    .status_i    (status),
    .rdata_o     (rdata_o)
  );

  a_r7_cw_sets_null: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cw_we_i |=> null_cnt);
  a_r1_cw_held_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cw_we_i |=> $stable(cw_o));
endmodule

// File: tb/cnt_latch_unit_tb_top.sv
module cnt_latch_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cw_we_i = 1'b0;
  logic [5:0]  cw_i = '0;
  logic        wr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        rd_i = 1'b0;
  logic        cnt_latch_i = 1'b0;
  logic        sts_latch_i = 1'b0;
  logic [15:0] ce_value_i = '0;
  logic        ce_load_i = 1'b0;
  logic        out_pin_i = 1'b0;
  logic [5:0]  cw_o;
  logic [15:0] cr_o;
  logic        cr_valid_o;
  logic [7:0]  rdata_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  int    kind_q[$];
  int    exp_q[$];
  string tag_q[$];
  event  ev;

  always #4 clk = ~clk;

  cnt_latch_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cw_we_i(cw_we_i), .cw_i(cw_i),
    .wr_i(wr_i), .wdata_i(wdata_i), .rd_i(rd_i), .cnt_latch_i(cnt_latch_i),
    .sts_latch_i(sts_latch_i), .ce_value_i(ce_value_i), .ce_load_i(ce_load_i),
    .out_pin_i(out_pin_i), .cw_o(cw_o), .cr_o(cr_o), .cr_valid_o(cr_valid_o),
    .rdata_o(rdata_o)
  );

  // monitor: pops the next expectation and compares it with the port
  always @(ev) begin
    int k, e, a;
    string t;
    k = kind_q.pop_front();
    e = exp_q.pop_front();
    t = tag_q.pop_front();
    case (k)
      0:       a = int'(rdata_o);
      1:       a = int'(cr_o);
      default: a = int'(cr_valid_o);
    endcase
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", t, a, e);
    end
  end

  task automatic push(int k, int e, string t);
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
    ->ev;
  endtask

  task automatic chk(int k, int e, string t);
    #1; push(k, e, t);
  endtask

  task automatic rd_chk(int e, string t);
    rd_i = 1'b1; #1; push(0, e, t);
    @(negedge clk); rd_i = 1'b0;
  endtask

  task automatic cw(logic [5:0] v);
    cw_we_i = 1'b1; cw_i = v; @(negedge clk); cw_we_i = 1'b0;
  endtask

  task automatic wr(logic [7:0] b);
    wr_i = 1'b1; wdata_i = b; @(negedge clk); wr_i = 1'b0;
  endtask

  task automatic lat_c();
    cnt_latch_i = 1'b1; @(negedge clk); cnt_latch_i = 1'b0;
  endtask

  task automatic lat_s();
    sts_latch_i = 1'b1; @(negedge clk); sts_latch_i = 1'b0;
  endtask

  task automatic ld();
    ce_load_i = 1'b1; @(negedge clk); ce_load_i = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    ce_value_i = 16'h1234;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(0, 8'h34, "R1 live low byte after reset");
    chk(1, 0, "R1 cr reset");
    chk(2, 0, "R1 valid reset");
    lat_s();
    rd_chk(8'h70, "R1 reset status");

    cw(6'h34);
    wr(8'hCD);
    chk(2, 0, "R3 no pulse on first byte");
    chk(1, 0, "R3 partial count hidden");
    wr(8'hAB);
    chk(1, 16'hABCD, "R2 two-byte count");
    chk(2, 1, "R2 valid pulse");
    @(negedge clk);
    chk(2, 0, "R3 pulse lasts one cycle");

    out_pin_i = 1'b1;
    lat_s();
    rd_chk(8'hF4, "R7 null set by count");
    ld();
    lat_s();
    rd_chk(8'hB4, "R7 null cleared by load");

    cw(6'h10);
    wr(8'h5A);
    chk(1, 16'h005A, "R2 low only");
    cw(6'h20);
    wr(8'h77);
    chk(1, 16'h7700, "R2 high only");

    ce_value_i = 16'h9876;
    rd_chk(8'h98, "R10 high format");
    rd_chk(8'h98, "R10 high format repeat");
    cw(6'h10);
    rd_chk(8'h76, "R10 low format");
    cw(6'h30);
    rd_chk(8'h76, "R10 pair low");
    rd_chk(8'h98, "R10 pair high");
    rd_chk(8'h76, "R10 pair wraps");

    cw(6'h30);
    ce_value_i = 16'h1111;
    lat_c();
    ce_value_i = 16'h2222;
    lat_c();
    rd_chk(8'h11, "R4 frozen low, second latch ignored");
    ce_value_i = 16'h3333;
    rd_chk(8'h11, "R4 frozen high");
    rd_chk(8'h33, "R4 follows after release");

    cw(6'h30);
    out_pin_i = 1'b0;
    lat_s();
    out_pin_i = 1'b1;
    lat_s();
    rd_chk(8'h70, "R5 first status kept");
    rd_chk(8'h33, "R5 status consumed once");

    cw(6'h30);
    ce_value_i = 16'h4455;
    lat_c();
    out_pin_i = 1'b1;
    lat_s();
    ce_value_i = 16'h6677;
    rd_chk(8'hF0, "R6 status first");
    rd_chk(8'h55, "R6 latched low");
    rd_chk(8'h44, "R6 latched high");
    rd_chk(8'h77, "R6 live after");

    cw(6'h30);
    out_pin_i = 1'b0;
    lat_s();
    lat_c();
    ce_value_i = 16'h0000;
    rd_chk(8'h70, "R6 status first when latched first");
    rd_chk(8'h77, "R6 count low");
    rd_chk(8'h66, "R6 count high");

    cw(6'h30);
    ce_value_i = 16'hA1B2;
    lat_c();
    rd_chk(8'hB2, "R8 read low");
    wr(8'h01);
    rd_chk(8'hA1, "R8 read high");
    wr(8'h02);
    chk(1, 16'h0201, "R8 interleaved write");

    cw(6'h30);
    wr(8'hEE);
    ce_value_i = 16'h1357;
    lat_c();
    lat_s();
    cw(6'h30);
    ce_value_i = 16'h2468;
    rd_chk(8'h68, "R9 latches released");
    wr(8'h11);
    wr(8'h22);
    chk(1, 16'h2211, "R9 write pointer reset");

    ld();
    cw_we_i = 1'b1; cw_i = 6'h30; ce_load_i = 1'b1;
    @(negedge clk);
    cw_we_i = 1'b0; ce_load_i = 1'b0;
    lat_s();
    rd_chk(8'h70, "R7 set wins over load");

    @(negedge clk);
    done = 1'b1;
    summary();
  end
endmodule